// File: doc/BRIEF.md
# Frame-Counting Receive Byte FIFO

This block holds whole received HDLC frames as bytes between a deframer and a host. The deframer pushes each frame's bytes over a valid/ready stream and marks the final byte, which is the status byte, with `wr_last`. Accepting that byte commits the frame. Bytes are tracked by write and read pointers. Frame boundaries are tracked by two circular counters. The writer's counter advances on every committed frame. The host's counter advances only when the host strobes `frm_done`. A table of end pointers, indexed by frame number, gives the host the length of the oldest pending frame and the start of the frame after it.

The read side presents the oldest pending frame as a valid/ready stream. The first four bytes of a frame come from a small prefetch buffer. A `sel_chg` strobe reloads that buffer from the start of the current frame and rewinds the read pointer to that start. If the host skips the strobe, it sees stale buffer bytes. Two limits bound storage: the byte capacity and the number of frame entries. A frame that would exceed either limit is dropped, and the write pointer returns to the frame's start.

The write stream has no back-pressure: `wr_ready` is high whenever the block is out of reset, and overflow is handled by dropping the frame. The read stream moves one byte on every cycle in which `rd_valid` and `rd_ready` are both high. While `rd_ready` is low, `rd_valid` and `rd_data` hold.

Top module: `rx_frame_fifo`

## Requirements
- R1: Every `wr_valid` beat is accepted. A beat with `wr_last` high commits the frame, and `frm_pend` rises by one on the next cycle. Bytes before that beat leave `frm_pend` unchanged.
- R2: `frm_pend` equals committed frames minus host-released frames, modulo 2^FW, and moves by at most one per cycle.
- R3: While a frame is pending, `frm_len` gives the byte count of the oldest pending frame, status byte included, modulo the depth. With nothing pending it reads 0.
- R4: `rd_valid` is high only while a frame is pending, no buffer reload is running and unread bytes remain. Bytes arrive in write order, `rd_last` marks the final byte, and after that byte is taken `rd_valid` stays low until `frm_done` or `sel_chg`.
- R5: `frm_done` releases the oldest pending frame, whether or not it has been read in full, and reading continues at the next frame's first byte. A `frm_done` given while `frm_pend` is 0 is ignored.
- R6: `sel_chg` rewinds reading to the first byte of the current frame. It then fills the 4-byte prefetch buffer from that point over the next four cycles, with `rd_valid` low during the fill. Byte offsets 0 to 3 of the frame are then served from that buffer.
- R7: When no `sel_chg` is given after `frm_done`, offsets 0 to 3 of the next frame return the buffer contents from the last fill. From offset 4 on, bytes come from storage.
- R8: A frame that starts or continues while `frm_pend` equals 2^FW-1 is dropped and never counted.
- R9: At most DEPTH-1 bytes are held, and this count includes the unreleased frame the host is on. A byte that finds the store full drops its frame: the write pointer returns to the frame start and later bytes are discarded up to and including the `wr_last` beat. A frame that exactly fills the store is kept.
- R10: `fifo_empty` is high exactly when no frame is pending and the write pointer equals the read pointer. A partly written frame clears it.
- R11: In reset, `frm_pend` is 0, `fifo_empty` is 1, and `rd_valid` and `wr_ready` are 0. `wr_ready` is 1 from the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write byte present |
| wr_ready | output | 1 | Write accepted (high outside reset) |
| wr_data | input | DW | Write byte |
| wr_last | input | 1 | Byte is the frame's status byte; commits the frame |
| rd_valid | output | 1 | Read byte present |
| rd_ready | input | 1 | Host takes the read byte |
| rd_data | output | DW | Read byte |
| rd_last | output | 1 | Read byte is the last of its frame |
| sel_chg | input | 1 | Rewind to frame start and refill prefetch buffer |
| frm_done | input | 1 | Release the oldest pending frame |
| frm_pend | output | FW | Number of pending complete frames |
| frm_len | output | AW | Length of the oldest pending frame |
| fifo_empty | output | 1 | No frame pending and no partial data |

## Verification
The bench pushes single frames of every length from 1 to the full capacity, one at a time. Together these wrap both pointers several times and check that length, order and the last-byte marker all hold across the wrap point. Back-to-back short frames fill the frame entries, while a long frame followed by an oversized one hits the byte limit. A frame that fills the store exactly separates the drop boundary from an off-by-one. A second read without a refresh shows the stale buffer bytes against fresh storage bytes. A partial read followed by a refresh tests the rewind. Releasing an unread frame, and releasing when nothing is pending, show that skipping a frame and the ignore rule work.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int PF_DEPTH = 4;

  typedef enum logic {
    WR_STORE = 1'b0,
    WR_DROP  = 1'b1
  } wr_state_e;
endpackage

// File: rtl/rxf_byte_store.sv
module rxf_byte_store #(
  parameter int DW = 8,
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rxf_end_table.sv
module rxf_end_table #(
  parameter int AW = 9,
  parameter int FW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [FW-1:0] widx,
  input  logic [AW-1:0] wdata,
  input  logic [FW-1:0] ridx,
  output logic [AW-1:0] rdata
);
  localparam int ENTRIES = 1 << FW;

  logic [AW-1:0] ends [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)                        ends[e] <= '0;
      else if (we && widx == FW'(e))     ends[e] <= wdata;
    end
  end

  assign rdata = ends[ridx];
endmodule

// File: rtl/rxf_wr_ctrl.sv
module rxf_wr_ctrl
  import rxf_pkg::*;
#(
  parameter int AW = 9,
  parameter int FW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic          wr_last,
  input  logic [AW-1:0] rd_base,
  input  logic [FW-1:0] f_rd,
  output logic          wr_ready,
  output logic          mem_we,
  output logic [AW-1:0] wr_ptr,
  output logic [FW-1:0] f_wr,
  output logic          tab_we,
  output logic [FW-1:0] tab_widx,
  output logic [AW-1:0] tab_wdata
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] BYTES_FULL = AW'(DEPTH - 1);
  localparam logic [FW-1:0] FRAMES_FULL = FW'((1 << FW) - 1);

  wr_state_e     state;
  logic          rdy_q;
  logic [AW-1:0] frm_start;
  logic          accept;
  logic          no_room;
  logic          commit;
  logic [AW-1:0] ptr_inc;

  assign accept  = wr_valid && rdy_q;
  assign no_room = ((wr_ptr - rd_base) == BYTES_FULL) || ((f_wr - f_rd) == FRAMES_FULL);
  assign mem_we  = accept && (state == WR_STORE) && !no_room;
  assign commit  = mem_we && wr_last;
  assign ptr_inc = wr_ptr + AW'(1);

  assign wr_ready  = rdy_q;
  assign tab_we    = commit;
  assign tab_widx  = f_wr + FW'(1);
  assign tab_wdata = ptr_inc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= WR_STORE;
      rdy_q     <= 1'b0;
      wr_ptr    <= '0;
      frm_start <= '0;
      f_wr      <= '0;
    end else begin
      rdy_q <= 1'b1;
      if (accept) begin
        case (state)
          WR_STORE: begin
            if (no_room) begin
              wr_ptr <= frm_start;
              if (!wr_last) state <= WR_DROP;
            end else begin
              wr_ptr <= ptr_inc;
              if (wr_last) begin
                frm_start <= ptr_inc;
                f_wr      <= f_wr + FW'(1);
              end
            end
          end
          WR_DROP: begin
            if (wr_last) state <= WR_STORE;
          end
          default: state <= WR_STORE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rxf_rd_ctrl.sv
module rxf_rd_ctrl
  import rxf_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 9,
  parameter int FW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] f_wr,
  input  logic [AW-1:0] cur_end,
  input  logic [DW-1:0] mem_rdata,
  input  logic          rd_ready,
  input  logic          sel_chg,
  input  logic          frm_done,
  output logic [AW-1:0] rd_ptr,
  output logic [AW-1:0] rd_base,
  output logic [FW-1:0] f_rd,
  output logic [AW-1:0] mem_raddr,
  output logic [FW-1:0] tab_ridx,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          rd_last,
  output logic [AW-1:0] frm_len,
  output logic [FW-1:0] frm_pend
);
  localparam int LC_W = $clog2(PF_DEPTH);
  localparam int OF_W = LC_W + 1;

  logic [DW-1:0]   pbuf [PF_DEPTH];
  logic            loading;
  logic [LC_W-1:0] load_cnt;
  logic [OF_W-1:0] rd_off;
  logic            have_frame;
  logic            take;
  logic            release_f;
  logic [AW-1:0]   next_base;
  logic            in_buf;

  assign frm_pend   = f_wr - f_rd;
  assign have_frame = (frm_pend != '0);
  assign tab_ridx   = f_rd + FW'(1);
  assign frm_len    = have_frame ? (cur_end - rd_base) : '0;
  assign mem_raddr  = loading ? (rd_base + AW'(load_cnt)) : rd_ptr;
  assign rd_valid   = have_frame && !loading && (rd_ptr != cur_end);
  assign rd_last    = (rd_ptr + AW'(1)) == cur_end;
  assign in_buf     = rd_off < OF_W'(PF_DEPTH);
  assign rd_data    = in_buf ? pbuf[rd_off[LC_W-1:0]] : mem_rdata;
  assign take       = rd_valid && rd_ready;
  assign release_f  = frm_done && have_frame;
  assign next_base  = release_f ? cur_end : rd_base;

  for (genvar k = 0; k < PF_DEPTH; k++) begin : g_pbuf
    always_ff @(posedge clk) begin
      if (!rst_n)                                 pbuf[k] <= '0;
      else if (loading && load_cnt == LC_W'(k))   pbuf[k] <= mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_rd     <= '0;
      rd_ptr   <= '0;
      rd_base  <= '0;
      rd_off   <= '0;
      loading  <= 1'b0;
      load_cnt <= '0;
    end else begin
      if (release_f) begin
        f_rd    <= f_rd + FW'(1);
        rd_base <= cur_end;
      end
      if (sel_chg) begin
        rd_ptr   <= next_base;
        rd_off   <= '0;
        loading  <= 1'b1;
        load_cnt <= '0;
      end else if (release_f) begin
        rd_ptr <= cur_end;
        rd_off <= '0;
      end else if (take) begin
        rd_ptr <= rd_ptr + AW'(1);
        if (in_buf) rd_off <= rd_off + OF_W'(1);
      end
      if (loading && !sel_chg) begin
        load_cnt <= load_cnt + LC_W'(1);
        if (load_cnt == LC_W'(PF_DEPTH - 1)) loading <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rx_frame_fifo.sv
module rx_frame_fifo #(
  parameter int DW = 8,
  parameter int AW = 9,
  parameter int FW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_last,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic          rd_last,
  input  logic          sel_chg,
  input  logic          frm_done,
  output logic [FW-1:0] frm_pend,
  output logic [AW-1:0] frm_len,
  output logic          fifo_empty
);
  logic          mem_we;
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [AW-1:0] rd_base;
  logic [FW-1:0] f_wr;
  logic [FW-1:0] f_rd;
  logic          tab_we;
  logic [FW-1:0] tab_widx;
  logic [AW-1:0] tab_wdata;
  logic [FW-1:0] tab_ridx;
  logic [AW-1:0] cur_end;
  logic [AW-1:0] mem_raddr;
  logic [DW-1:0] mem_rdata;

  rxf_wr_ctrl #(.AW(AW), .FW(FW)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_last(wr_last),
    .rd_base(rd_base), .f_rd(f_rd), .wr_ready(wr_ready), .mem_we(mem_we),
    .wr_ptr(wr_ptr), .f_wr(f_wr), .tab_we(tab_we), .tab_widx(tab_widx),
    .tab_wdata(tab_wdata)
  );

  rxf_byte_store #(.DW(DW), .AW(AW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(wr_ptr), .wdata(wr_data),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  rxf_end_table #(.AW(AW), .FW(FW)) u_tab (
    .clk(clk), .rst_n(rst_n), .we(tab_we), .widx(tab_widx), .wdata(tab_wdata),
    .ridx(tab_ridx), .rdata(cur_end)
  );

  rxf_rd_ctrl #(.DW(DW), .AW(AW), .FW(FW)) u_rd (
    .clk(clk), .rst_n(rst_n), .f_wr(f_wr), .cur_end(cur_end),
    .mem_rdata(mem_rdata), .rd_ready(rd_ready), .sel_chg(sel_chg),
    .frm_done(frm_done), .rd_ptr(rd_ptr), .rd_base(rd_base), .f_rd(f_rd),
    .mem_raddr(mem_raddr), .tab_ridx(tab_ridx), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_last(rd_last), .frm_len(frm_len),
    .frm_pend(frm_pend)
  );

  assign fifo_empty = (frm_pend == '0) && (wr_ptr == rd_ptr);
endmodule

// File: rtl/rx_frame_fifo_chk.sv
module rx_frame_fifo_chk #(
  parameter int AW = 9,
  parameter int FW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_ready,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic          rd_last,
  input logic          sel_chg,
  input logic          frm_done,
  input logic [FW-1:0] frm_pend,
  input logic [AW-1:0] frm_len,
  input logic          fifo_empty
);
  // R11
  ready_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> wr_ready);

  // R2
  pend_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (frm_pend == $past(frm_pend)) || (frm_pend == $past(frm_pend) + FW'(1))
             || (frm_pend == $past(frm_pend) - FW'(1)));

  // R4
  valid_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> frm_pend != '0);

  // R4
  last_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && rd_last && !frm_done && !sel_chg) |=> !rd_valid);

  // R6
  refill_blanks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_chg |=> !rd_valid);

  // R5
  done_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_done && frm_pend == '0) |=> frm_pend <= FW'(1));

  // R10
  empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |-> (frm_pend == '0) && !rd_valid);

  // R3
  len_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_pend == '0) |-> frm_len == '0);
endmodule

bind rx_frame_fifo rx_frame_fifo_chk #(.AW(AW), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_ready(wr_ready), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_last(rd_last), .sel_chg(sel_chg),
  .frm_done(frm_done), .frm_pend(frm_pend), .frm_len(frm_len),
  .fifo_empty(fifo_empty)
);

// File: tb/rx_frame_fifo_test.sv
module rx_frame_fifo_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int FW = 2;
  localparam int DEPTH = 1 << AW;
  localparam int MASK = DEPTH - 1;
  localparam int MAXF = (1 << FW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [DW-1:0] wr_data = '0;
  logic wr_last = 1'b0;
  logic rd_valid;
  logic rd_ready = 1'b0;
  logic [DW-1:0] rd_data;
  logic rd_last;
  logic sel_chg = 1'b0;
  logic frm_done = 1'b0;
  logic [FW-1:0] frm_pend;
  logic [AW-1:0] frm_len;
  logic fifo_empty;

  int total = 0;
  int bad = 0;

  // model state
  logic [7:0] m_mem [DEPTH];
  logic [7:0] m_buf [4];
  int m_wp = 0, m_start = 0, m_base = 0;
  int q_len [8];
  int q_head = 0, q_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_frame_fifo #(.DW(DW), .AW(AW), .FW(FW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .wr_last(wr_last), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .rd_last(rd_last),
    .sel_chg(sel_chg), .frm_done(frm_done), .frm_pend(frm_pend),
    .frm_len(frm_len), .fifo_empty(fifo_empty)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 37 + i * 11 + 5) & 8'hff);
  endfunction

  // Writes one frame; model decides storage vs. drop (R8, R9).
  task automatic push_frame(input int len, input int seed);
    bit drop = 0;
    int pend0 = q_cnt;
    for (int i = 0; i < len; i++) begin
      wr_valid = 1'b1;
      wr_data  = pat(seed, i);
      wr_last  = (i == len - 1);
      if (!drop) begin
        if (q_cnt == MAXF || ((m_wp - m_base) & MASK) == MASK) begin
          drop = 1;
          m_wp = m_start;
        end else begin
          m_mem[m_wp] = pat(seed, i);
          m_wp = (m_wp + 1) & MASK;
        end
      end
      @(negedge clk);
      if (i == 0 && len > 1 && !drop) begin
        chk(fifo_empty == 1'b0, "R10", "empty during partial frame", int'(fifo_empty), 0);
        chk(int'(frm_pend) == pend0, "R1", "pend before last byte", int'(frm_pend), pend0);
      end
    end
    wr_valid = 1'b0;
    wr_last  = 1'b0;
    if (!drop) begin
      q_len[(q_head + q_cnt) & 7] = len;
      q_cnt++;
      m_start = m_wp;
    end
    chk(int'(frm_pend) == q_cnt, drop ? "R8" : "R1", "pend after frame", int'(frm_pend), q_cnt);
  endtask

  // Reads nread bytes of the oldest frame; a full read also releases it.
  task automatic read_frame(input bit refresh, input int nread);
    int len = q_len[q_head];
    int w = 0;
    logic [7:0] exp;
    chk(int'(frm_len) == len, "R3", "frame length", int'(frm_len), len);
    if (refresh) begin
      sel_chg = 1'b1;
      @(negedge clk);
      sel_chg = 1'b0;
      chk(rd_valid == 1'b0, "R6", "valid during refill", int'(rd_valid), 0);
      for (int k = 0; k < 4; k++) m_buf[k] = m_mem[(m_base + k) & MASK];
    end
    rd_ready = 1'b1;
    while (!rd_valid && w < 20) begin
      @(negedge clk);
      w++;
    end
    for (int i = 0; i < nread; i++) begin
      if (i > 0) @(negedge clk);
      exp = (i < 4) ? m_buf[i] : m_mem[(m_base + i) & MASK];
      chk(rd_valid && rd_data == exp, refresh ? "R4" : "R7", "read byte",
          int'(rd_data), int'(exp));
      if (nread == len)
        chk(rd_last == (i == len - 1), "R4", "last marker", int'(rd_last), int'(i == len - 1));
    end
    @(negedge clk);
    rd_ready = 1'b0;
    if (nread == len) begin
      chk(rd_valid == 1'b0, "R4", "valid after last byte", int'(rd_valid), 0);
      frm_done = 1'b1;
      @(negedge clk);
      frm_done = 1'b0;
      m_base = (m_base + len) & MASK;
      q_head = (q_head + 1) & 7;
      q_cnt--;
      chk(int'(frm_pend) == q_cnt, "R5", "pend after release", int'(frm_pend), q_cnt);
    end
  endtask

  task automatic skip_frame();
    frm_done = 1'b1;
    @(negedge clk);
    frm_done = 1'b0;
    m_base = (m_base + q_len[q_head]) & MASK;
    q_head = (q_head + 1) & 7;
    q_cnt--;
    chk(int'(frm_pend) == q_cnt, "R5", "pend after unread release", int'(frm_pend), q_cnt);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) m_buf[k] = 8'h00;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(frm_pend == '0, "R11", "pend in reset", int'(frm_pend), 0);
    chk(fifo_empty == 1'b1, "R11", "empty in reset", int'(fifo_empty), 1);
    chk(rd_valid == 1'b0, "R11", "rd_valid in reset", int'(rd_valid), 0);
    chk(wr_ready == 1'b0, "R11", "wr_ready in reset", int'(wr_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wr_ready == 1'b1, "R11", "wr_ready after reset", int'(wr_ready), 1);

    // R5: release while nothing pending is ignored
    frm_done = 1'b1;
    @(negedge clk);
    frm_done = 1'b0;
    chk(frm_pend == '0, "R5", "pend after idle release", int'(frm_pend), 0);
    chk(fifo_empty == 1'b1, "R10", "empty after idle release", int'(fifo_empty), 1);

    // Sweep every length with pointer wrap (R1, R3, R4, R6, R10)
    for (int rep = 0; rep < 2; rep++) begin
      for (int len = 1; len <= MASK; len++) begin
        push_frame(len, len + rep * 20);
        read_frame(1'b1, len);
        chk(fifo_empty == 1'b1, "R10", "empty after drain", int'(fifo_empty), 1);
      end
    end

    // R8: frame entries exhausted
    for (int f = 0; f <= MAXF; f++) push_frame(2, 50 + f);
    chk(int'(frm_pend) == MAXF, "R8", "pend at frame limit", int'(frm_pend), MAXF);
    for (int f = 0; f < MAXF; f++) read_frame(1'b1, 2);

    // R9: byte limit, then an exact fit
    push_frame(10, 60);
    push_frame(8, 61);
    chk(int'(frm_pend) == 1, "R9", "pend after byte overflow", int'(frm_pend), 1);
    push_frame(5, 62);
    chk(int'(frm_pend) == 2, "R9", "pend after exact fit", int'(frm_pend), 2);
    read_frame(1'b1, 10);
    read_frame(1'b1, 5);

    // R7: second frame read without refresh returns stale first bytes
    push_frame(6, 70);
    push_frame(7, 71);
    read_frame(1'b1, 6);
    read_frame(1'b0, 7);

    // R6: partial read, then refresh rewinds to the frame start
    push_frame(7, 80);
    read_frame(1'b1, 3);
    read_frame(1'b1, 7);

    // R5: releasing an unread frame moves to the next one
    push_frame(5, 90);
    push_frame(4, 91);
    skip_frame();
    read_frame(1'b1, 4);
    chk(fifo_empty == 1'b1, "R10", "empty at end", int'(fifo_empty), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule